// File: doc/BRIEF.md
# Asymmetric Edge-Delayed Transmit/Receive Switch Controller

This block drives an external antenna switch between transmit and receive. Its request input is a transmit-activity flag, normally the not-empty flag of the transmit FIFO. That flag goes high as soon as data is queued, but the samples then spend a fixed time in the interpolator and converter pipeline before they reach the antenna. Switching on the raw flag would therefore turn the switch too early on the way in and too early on the way out, which would cut off the tail of each burst.

The controller adds a separate programmable delay to each switch direction, counted in ticks of its own clock. A switch into transmit waits for the transmit delay. A switch back to receive waits for the receive delay, which is usually set somewhat longer than the pipeline latency so that the output energy has fully decayed. The pipeline latency is roughly 50 ticks plus 3 ticks per unit of interpolation rate. A single down-counter times the pending transition. If the request falls back before the countdown expires, the transition is cancelled. A small write port loads the two delay registers at run time.

Top module: `tr_switch_ctrl`

## Requirements
- R1: After reset, tx_sel_o is 0, rx_sel_o is 1, no transition is pending, and both delay registers hold 0.
- R2: rx_sel_o is always the complement of tx_sel_o. The two are never high together.
- R3: Let edge k be the first clock edge that samples tx_active_i high while tx_sel_o is low and nothing is pending. With transmit delay D, tx_sel_o goes high at edge k+D and stays high from then on. D = 0 therefore gives a one-cycle registered response.
- R4: Let edge k be the first clock edge that samples tx_active_i low while tx_sel_o is high and nothing is pending. With receive delay D, tx_sel_o goes low at edge k+D.
- R5: The transmit delay and the receive delay are independent. Each one affects only its own switch direction.
- R6: If tx_active_i returns to the current output level before a pending countdown expires, the transition is cancelled. The output does not change and the counter goes idle. A later change of the request reloads the full delay.
- R7: A write with wr_en_i = 1 loads wr_data_i into the transmit delay when wr_sel_i = 0, and into the receive delay when wr_sel_i = 1. The new value applies from the next edge event onward. A countdown already in progress keeps the value it was loaded with.
- R8: tx_sel_o changes only toward the level of tx_active_i sampled at the same edge. It never toggles while the request already equals the output.
- R9: Delays up to the largest 12-bit value (4095) are timed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the delays count ticks of this clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Raw switch request (transmit FIFO not empty) |
| wr_en_i | input | 1 | Delay register write strobe |
| wr_sel_i | input | 1 | 0 selects the transmit delay, 1 selects the receive delay |
| wr_data_i | input | 12 | Delay value in clock ticks |
| tx_sel_o | output | 1 | Delayed transmit-select |
| rx_sel_o | output | 1 | Registered complement of tx_sel_o |

## Verification
The assertions check the following on every cycle:
- the two outputs are mutually exclusive;
- any output change follows the sampled request;
- a zero delay gives a one-edge response;
- a cancelled countdown leaves the output unchanged;
- the counter stays at zero when no transition is pending.

The exact D-edge latency of each direction, the independence of the two delays, the full reload after a cancel, and the rule that a write does not disturb a running countdown can only be shown by the bench's scenarios. The bench sweeps pairs of delays, including the 12-bit maximum, and measures each latency against the programmed value.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam int unsigned DLY_W_DEF = 12;
  localparam int unsigned N_DLY     = 2;

  typedef enum logic {
    SEL_RISE = 1'b0,
    SEL_FALL = 1'b1
  } dly_sel_e;
endpackage

// File: rtl/tr_delay_regs.sv
module tr_delay_regs #(
  parameter int unsigned DLY_W = tr_pkg::DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [DLY_W-1:0] wr_data_i,
  output logic [DLY_W-1:0] rise_dly_o,
  output logic [DLY_W-1:0] fall_dly_o
);
  logic [DLY_W-1:0] dly_q [tr_pkg::N_DLY];

  for (genvar g = 0; g < tr_pkg::N_DLY; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q[g] <= '0;
      end else if (wr_en_i && (wr_sel_i == 1'(g))) begin
        dly_q[g] <= wr_data_i;
      end
    end
  end

  assign rise_dly_o = dly_q[tr_pkg::SEL_RISE];
  assign fall_dly_o = dly_q[tr_pkg::SEL_FALL];
endmodule

// File: rtl/tr_edge_timer.sv
module tr_edge_timer #(
  parameter int unsigned DLY_W = tr_pkg::DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cur_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  output logic             flip_o,
  output logic             busy_o,
  output logic [DLY_W-1:0] cnt_o
);
  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dly_sel;

  // output high means the next move is a fall
  assign dly_sel = cur_i ? fall_dly_i : rise_dly_i;

  always_comb begin
    flip_o = 1'b0;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (req_i == cur_i) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (!pend_q) begin
      if (dly_sel == '0) begin
        flip_o = 1'b1;
      end else begin
        pend_d = 1'b1;
        cnt_d  = dly_sel;
      end
    end else if (cnt_q == DLY_W'(1)) begin
      flip_o = 1'b1;
      pend_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = pend_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tr_switch_out.sv
module tr_switch_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  output logic tx_sel_o,
  output logic rx_sel_o
);
  logic tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b1;
    end else if (flip_i) begin
      tx_q <= ~tx_q;
      rx_q <= tx_q;
    end
  end

  assign tx_sel_o = tx_q;
  assign rx_sel_o = rx_q;
endmodule

// File: rtl/tr_switch_ctrl.sv
module tr_switch_ctrl #(
  parameter int unsigned DLY_W = tr_pkg::DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_active_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [DLY_W-1:0] wr_data_i,
  output logic             tx_sel_o,
  output logic             rx_sel_o
);
  logic [DLY_W-1:0] rise_dly, fall_dly, tmr_cnt;
  logic             flip, busy;

  tr_delay_regs #(.DLY_W(DLY_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rise_dly_o (rise_dly),
    .fall_dly_o (fall_dly)
  );

  tr_edge_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (tx_active_i),
    .cur_i      (tx_sel_o),
    .rise_dly_i (rise_dly),
    .fall_dly_i (fall_dly),
    .flip_o     (flip),
    .busy_o     (busy),
    .cnt_o      (tmr_cnt)
  );

  tr_switch_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flip_i   (flip),
    .tx_sel_o (tx_sel_o),
    .rx_sel_o (rx_sel_o)
  );
endmodule

// File: rtl/tr_switch_ctrl_chk.sv
module tr_switch_ctrl_chk #(
  parameter int unsigned DLY_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_active_i,
  input logic             tx_sel_o,
  input logic             rx_sel_o,
  input logic             busy_i,
  input logic [DLY_W-1:0] cnt_i,
  input logic [DLY_W-1:0] rise_dly_i,
  input logic [DLY_W-1:0] fall_dly_i
);
  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sel_o != rx_sel_o);

  assert_rise_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_sel_o) |-> $past(tx_active_i));

  assert_fall_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_sel_o) |-> !$past(tx_active_i));

  assert_zero_dly_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && (tx_active_i != tx_sel_o) &&
     ((tx_sel_o ? fall_dly_i : rise_dly_i) == '0))
    |=> (tx_sel_o == $past(tx_active_i)));

  assert_cancel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (tx_active_i == tx_sel_o)) |=> (!busy_i && $stable(tx_sel_o)));

  assert_idle_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cnt_i == '0));
endmodule

bind tr_switch_ctrl tr_switch_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_active_i (tx_active_i),
  .tx_sel_o    (tx_sel_o),
  .rx_sel_o    (rx_sel_o),
  .busy_i      (busy),
  .cnt_i       (tmr_cnt),
  .rise_dly_i  (rise_dly),
  .fall_dly_i  (fall_dly)
);

// File: tb/tr_switch_ctrl_bench.sv
module tr_switch_ctrl_bench;
  localparam int DW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_active_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          tx_sel_o, rx_sel_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  tr_switch_ctrl #(.DLY_W(DW)) u_tr_switch_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .tx_sel_o    (tx_sel_o),
    .rx_sel_o    (rx_sel_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called right after a negedge; returns right after a negedge
  task automatic write_dly(input logic sel, input int val);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_data_i = DW'(val);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // drive the request to lvl; expect the output to follow after exp negedges (D+1)
  task automatic measure(input logic lvl, input int exp, input string req);
    int  n = 0;
    bit  excl_ok = 1'b1;
    tx_active_i = lvl;
    do begin
      @(negedge clk_i);
      n++;
      if (rx_sel_o == tx_sel_o) excl_ok = 1'b0;
    end while (tx_sel_o != lvl && n < exp + 8);
    check(n == exp, req, n, exp);
    check(excl_ok, "R2", int'(rx_sel_o), int'(~tx_sel_o));
  endtask

  // hold and verify the output does not move
  task automatic hold_check(input int cycles, input logic lvl, input string req);
    int bad_n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (tx_sel_o != lvl || rx_sel_o == tx_sel_o) bad_n++;
    end
    check(bad_n == 0, req, int'(tx_sel_o), int'(lvl));
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rise_set [6] = '{0, 1, 2, 3, 7, 50};
    int fall_set [5] = '{0, 1, 5, 13, 86};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(tx_sel_o == 1'b0, "R1", int'(tx_sel_o), 0);
    check(rx_sel_o == 1'b1, "R1", int'(rx_sel_o), 1);
    hold_check(5, 1'b0, "R1");
    // zero delays after reset: one-edge response both ways
    measure(1'b1, 1, "R1");
    measure(1'b0, 1, "R1");

    // R3/R4/R5 sweep of independent pairs
    foreach (rise_set[i]) begin
      foreach (fall_set[j]) begin
        write_dly(1'b0, rise_set[i]);
        write_dly(1'b1, fall_set[j]);
        hold_check(2, 1'b0, "R8");
        measure(1'b1, rise_set[i] + 1, "R3");
        hold_check(3, 1'b1, "R8");
        measure(1'b0, fall_set[j] + 1, "R4");
      end
    end

    // R5: change only the transmit delay, the receive latency stays
    write_dly(1'b1, 9);
    write_dly(1'b0, 4);
    measure(1'b1, 5, "R5");
    measure(1'b0, 10, "R5");
    write_dly(1'b0, 30);
    measure(1'b1, 31, "R5");
    measure(1'b0, 10, "R5");

    // R6 cancel of a rise, then full reload
    write_dly(1'b0, 10);
    tx_active_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check(tx_sel_o == 1'b0, "R6", int'(tx_sel_o), 0);
    tx_active_i = 1'b0;
    hold_check(25, 1'b0, "R6");
    measure(1'b1, 11, "R6");
    // R6 cancel of a fall
    write_dly(1'b1, 8);
    tx_active_i = 1'b0;
    repeat (6) @(negedge clk_i);
    tx_active_i = 1'b1;
    hold_check(20, 1'b1, "R6");
    measure(1'b0, 9, "R6");
    // single-cycle glitch is filtered
    tx_active_i = 1'b1;
    @(negedge clk_i);
    tx_active_i = 1'b0;
    hold_check(20, 1'b0, "R6");

    // R7: write during a countdown keeps the loaded value
    write_dly(1'b0, 20);
    begin
      int n = 0;
      tx_active_i = 1'b1;
      repeat (3) begin @(negedge clk_i); n++; end
      wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = DW'(2);
      @(negedge clk_i); n++;
      wr_en_i = 1'b0;
      while (tx_sel_o != 1'b1 && n < 40) begin @(negedge clk_i); n++; end
      check(n == 21, "R7", n, 21);
    end
    measure(1'b0, 9, "R7");
    measure(1'b1, 3, "R7");
    // write to receive delay affects only the fall
    write_dly(1'b1, 0);
    measure(1'b0, 1, "R7");
    measure(1'b1, 3, "R7");
    measure(1'b0, 1, "R7");

    // R9 maximum delay
    write_dly(1'b0, 4095);
    write_dly(1'b1, 4095);
    measure(1'b1, 4096, "R9");
    measure(1'b0, 4096, "R9");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule